// File: doc/BRIEF.md
# Dual-Strobe Multiplexed Host Bus Port

This block connects an asynchronous 8-bit parallel host bus to an internal register bus that runs on the system clock. It accepts either of two strobe styles, chosen by a static style input. In the first style the host uses separate active-low read and write strobes. In the second style it uses one active-low data strobe together with a read/write level. Every host pin is sampled through a two-stage synchronizer. A host access then becomes exactly one single-cycle request on the register side.

An address latch enable input lets a host share lines between address and data. While the latch enable is high, the address pins pass straight through. The address present at its falling edge is held until it rises again. A host with a non-multiplexed bus ties it high. The data bus is split into an input, an output and an output enable, which a pad ring combines into the tri-state pins. The enable is gated directly by the raw chip select and the raw read condition, so the port stops driving the bus as soon as the host withdraws.

The register bus has no back-pressure. A request is a one-cycle pulse that the register file must accept in the same cycle. For a read, `reg_rdata` must be valid, as a combinational function of `reg_addr`, while `reg_rd` is high.

Top module: `hbi_host_port`

## Requirements
- R1: With `hb_mode`=0, a read condition exists while `hb_cs_n`=0 and `hb_stb_a_n`=0. Each read condition produces one `reg_rd` pulse carrying the address.
- R2: With `hb_mode`=0, a write condition exists while `hb_cs_n`=0 and `hb_stb_b_n`=0. When it ends (write strobe rising), exactly one `reg_wr` pulse is produced. Its `reg_wdata` is the value of `hb_din` at the last clock edge that sampled the condition active.
- R3: With `hb_mode`=1, `hb_stb_a_n` is the data strobe and `hb_stb_b_n` is the read/write level. The strobe low with `hb_stb_b_n`=1 is a read. The strobe low with `hb_stb_b_n`=0 is a write, committed when the strobe rises.
- R4: While `hb_cs_n`=1, the strobes produce no request and `hb_doe` stays 0.
- R5: While `rst_n`=0, `hb_doe`, `reg_rd` and `reg_wr` are 0, and an access in progress is abandoned.
- R6: While `hb_ale`=1, the live `hb_addr` value is used. While it is 0, the address sampled at the last edge before it fell is used.
- R7: A read condition held for any number of cycles yields only one `reg_rd` pulse.
- R8: `hb_doe` goes to 0 in the same cycle that the raw read condition ends, through either the strobe or chip select.
- R9: `reg_rd` is high in the cycle after the second clock edge following the first edge that samples the read condition. `reg_wr` keeps the same spacing from the first edge that samples the write condition ended.
- R10: The port samples `reg_rdata` in the `reg_rd` cycle. From the next edge, `hb_dout` holds that byte and `hb_doe` is 1 until the read ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_mode | input | 1 | Strobe style: 0 separate read/write strobes, 1 data strobe with read/write level |
| hb_cs_n | input | 1 | Chip select, active low |
| hb_stb_a_n | input | 1 | Read strobe (style 0) or data strobe (style 1), active low |
| hb_stb_b_n | input | 1 | Write strobe (style 0) or read/write level, 1 = read (style 1) |
| hb_ale | input | 1 | Address latch enable, transparent while high |
| hb_addr | input | 11 | Host address |
| hb_din | input | 8 | Data from the host bus pads |
| hb_dout | output | 8 | Data to the host bus pads |
| hb_doe | output | 1 | Pad output enable for the data bus |
| reg_rd | output | 1 | One-cycle register read request |
| reg_wr | output | 1 | One-cycle register write request |
| reg_addr | output | 11 | Register address of the current request |
| reg_wdata | output | 8 | Write data, valid with `reg_wr` |
| reg_rdata | input | 8 | Read data, valid while `reg_rd` is high |

## Verification
The hardest cases are those where the host ends an access out of order. Chip select can be withdrawn while the read strobe stays low. A reset can land while the port is driving read data. In a multiplexed cycle, the address pins carry unrelated data once the latch enable has fallen. The stimulus builds each of these directly: it keeps the strobe low after chip select rises, asserts reset in the middle of a driven read, and places a junk address on the pins during the strobe phase. A write also changes its data partway through the strobe, to show that the value committed is the one present at release.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

  typedef enum logic {
    STYLE_SPLIT  = 1'b0,
    STYLE_DSTROBE = 1'b1
  } strobe_style_e;

  function automatic logic rd_active(input logic mode, input logic cs_n,
                                     input logic a_n, input logic b_n);
    if (cs_n) return 1'b0;
    if (strobe_style_e'(mode) == STYLE_SPLIT) return ~a_n;
    return ~a_n & b_n;
  endfunction

  function automatic logic wr_active(input logic mode, input logic cs_n,
                                     input logic a_n, input logic b_n);
    if (cs_n) return 1'b0;
    if (strobe_style_e'(mode) == STYLE_SPLIT) return ~b_n;
    return ~a_n & ~b_n;
  endfunction

endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int         W      = 1,
  parameter int         STAGES = 2,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= RST;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hbi_strobe_decode.sv
module hbi_strobe_decode
  import hbi_pkg::*;
(
  input  logic mode,
  input  logic cs_n,
  input  logic stb_a_n,
  input  logic stb_b_n,
  output logic rd_act,
  output logic wr_act
);
  always_comb begin
    rd_act = rd_active(mode, cs_n, stb_a_n, stb_b_n);
    wr_act = wr_active(mode, cs_n, stb_a_n, stb_b_n);
  end
endmodule

// File: rtl/hbi_addr_latch.sv
module hbi_addr_latch #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale_s,
  input  logic [AW-1:0] addr_s,
  output logic [AW-1:0] eff_addr
);
  logic [AW-1:0] held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held_q <= '0;
    else if (ale_s) held_q <= addr_s;
  end

  assign eff_addr = ale_s ? addr_s : held_q;

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale_s && $past(!ale_s)) |-> $stable(eff_addr));
endmodule

// File: rtl/hbi_xfer.sv
module hbi_xfer #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_act,
  input  logic          wr_act,
  input  logic [AW-1:0] eff_addr,
  input  logic [DW-1:0] din_s,
  input  logic [DW-1:0] reg_rdata,
  output logic          reg_rd,
  output logic          reg_wr,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] dout_q,
  output logic          doe_q
);
  logic          rd_prev, wr_prev;
  logic [AW-1:0] waddr_q;
  logic [DW-1:0] wdata_q;
  logic          rd_start, wr_end;

  assign rd_start = rd_act & ~rd_prev;
  assign wr_end   = wr_prev & ~wr_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev   <= 1'b0;
      wr_prev   <= 1'b0;
      waddr_q   <= '0;
      wdata_q   <= '0;
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      dout_q    <= '0;
      doe_q     <= 1'b0;
    end else begin
      rd_prev <= rd_act;
      wr_prev <= wr_act;
      if (wr_act) begin
        waddr_q <= eff_addr;
        wdata_q <= din_s;
      end
      reg_wr <= wr_end;
      reg_rd <= rd_start & ~wr_end;
      if (wr_end) begin
        reg_addr  <= waddr_q;
        reg_wdata <= wdata_q;
      end else if (rd_start) begin
        reg_addr <= eff_addr;
      end
      if (!rd_act) begin
        doe_q <= 1'b0;
      end else if (reg_rd) begin
        doe_q  <= 1'b1;
        dout_q <= reg_rdata;
      end
    end
  end

  // R7
  rd_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  // R2
  wr_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  // R10
  doe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doe_q) |-> $past(reg_rd));
  // R8
  doe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_act |=> !doe_q);
endmodule

// File: rtl/hbi_host_port.sv
module hbi_host_port
  import hbi_pkg::*;
#(
  parameter int AW     = 11,
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hb_mode,
  input  logic          hb_cs_n,
  input  logic          hb_stb_a_n,
  input  logic          hb_stb_b_n,
  input  logic          hb_ale,
  input  logic [AW-1:0] hb_addr,
  input  logic [DW-1:0] hb_din,
  output logic [DW-1:0] hb_dout,
  output logic          hb_doe,
  output logic          reg_rd,
  output logic          reg_wr,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata
);
  localparam int CW = 5;
  localparam int BW = AW + DW;
  localparam logic [CW-1:0] CTRL_IDLE = 5'b0_1111;

  logic [CW-1:0] ctrl_s;
  logic [BW-1:0] bus_s;
  logic          mode_s, ale_s, cs_s, a_s, b_s;
  logic [AW-1:0] addr_s, eff_addr;
  logic [DW-1:0] din_s;
  logic          rd_act, wr_act, doe_q;

  hbi_sync #(.W(CW), .STAGES(STAGES), .RST(CTRL_IDLE)) u_ctrl_sync (
    .clk(clk), .rst_n(rst_n),
    .d({hb_mode, hb_ale, hb_cs_n, hb_stb_a_n, hb_stb_b_n}),
    .q(ctrl_s)
  );

  hbi_sync #(.W(BW), .STAGES(STAGES), .RST('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({hb_addr, hb_din}), .q(bus_s)
  );

  assign {mode_s, ale_s, cs_s, a_s, b_s} = ctrl_s;
  assign {addr_s, din_s} = bus_s;

  hbi_strobe_decode u_dec (
    .mode(mode_s), .cs_n(cs_s), .stb_a_n(a_s), .stb_b_n(b_s),
    .rd_act(rd_act), .wr_act(wr_act)
  );

  hbi_addr_latch #(.AW(AW)) u_alat (
    .clk(clk), .rst_n(rst_n), .ale_s(ale_s), .addr_s(addr_s),
    .eff_addr(eff_addr)
  );

  hbi_xfer #(.AW(AW), .DW(DW)) u_xfer (
    .clk(clk), .rst_n(rst_n), .rd_act(rd_act), .wr_act(wr_act),
    .eff_addr(eff_addr), .din_s(din_s), .reg_rdata(reg_rdata),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .dout_q(hb_dout), .doe_q(doe_q)
  );

  assign hb_doe = doe_q & rd_active(hb_mode, hb_cs_n, hb_stb_a_n, hb_stb_b_n);

  // R5
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_quiet_chk: assert (!hb_doe && !reg_rd && !reg_wr);
    end
  end

  // R4
  cs_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s)) |=> !reg_rd);
endmodule

// File: tb/hbi_host_port_test.sv
module hbi_host_port_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hb_mode = 1'b0, hb_cs_n = 1'b1, hb_stb_a_n = 1'b1, hb_stb_b_n = 1'b1;
  logic hb_ale = 1'b1;
  logic [10:0] hb_addr = '0;
  logic [7:0]  hb_din = '0;
  logic [7:0]  hb_dout;
  logic        hb_doe, reg_rd, reg_wr;
  logic [10:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbi_host_port uut (
    .clk(clk), .rst_n(rst_n), .hb_mode(hb_mode), .hb_cs_n(hb_cs_n),
    .hb_stb_a_n(hb_stb_a_n), .hb_stb_b_n(hb_stb_b_n), .hb_ale(hb_ale),
    .hb_addr(hb_addr), .hb_din(hb_din), .hb_dout(hb_dout), .hb_doe(hb_doe),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // register file seen by the port
  logic [7:0] mem [0:2047];
  logic [7:0] mm  [0:2047];
  initial for (int i = 0; i < 2048; i++) begin
    mem[i] = 8'(i * 7 + 3);
    mm[i]  = 8'(i * 7 + 3);
  end
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_wr) mem[reg_addr] <= reg_wdata;

  int vectors = 0, fails = 0;
  int cnt_rd = 0, cnt_wr = 0;
  always @(posedge clk) begin
    if (reg_rd) cnt_rd++;
    if (reg_wr) cnt_wr++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: history of pin snapshots, newest first
  typedef struct packed {
    logic cs_n, a_n, b_n, ale, mode;
    logic [10:0] addr, eff;
    logic [7:0]  din;
  } snap_t;
  localparam snap_t IDLE = '{cs_n:1'b1, a_n:1'b1, b_n:1'b1, ale:1'b1,
                             mode:1'b0, addr:11'd0, eff:11'd0, din:8'd0};
  snap_t h [$];
  logic [10:0] m_hold = '0;
  logic        e_rd = 0, e_wr = 0, e_doe = 0;
  logic [10:0] e_rd_addr = '0, e_wr_addr = '0;
  logic [7:0]  e_wdata = '0, e_dout = '0;

  function automatic bit m_rd(snap_t s);
    return !s.cs_n && !s.a_n && (s.mode == 1'b0 || s.b_n);
  endfunction
  function automatic bit m_wr(snap_t s);
    if (s.cs_n) return 0;
    return s.mode ? (!s.a_n && !s.b_n) : !s.b_n;
  endfunction

  initial for (int i = 0; i < 4; i++) h.push_back(IDLE);

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) h[i] = IDLE;
      m_hold = '0; e_rd = 0; e_wr = 0; e_doe = 0;
    end else begin
      snap_t s;
      logic p_rd, p_wr;
      logic [10:0] p_ra, p_wa;
      logic [7:0] p_wd;
      s = '{cs_n:hb_cs_n, a_n:hb_stb_a_n, b_n:hb_stb_b_n, ale:hb_ale,
            mode:hb_mode, addr:hb_addr, eff:(hb_ale ? hb_addr : m_hold), din:hb_din};
      if (hb_ale) m_hold = hb_addr;
      p_rd = e_rd; p_ra = e_rd_addr; p_wr = e_wr; p_wa = e_wr_addr; p_wd = e_wdata;
      h.push_front(s);
      void'(h.pop_back());
      e_rd = m_rd(h[2]) && !m_rd(h[3]);
      e_rd_addr = h[2].eff;
      e_wr = m_wr(h[3]) && !m_wr(h[2]);
      e_wr_addr = h[3].eff;
      e_wdata = h[3].din;
      if (!m_rd(h[2])) e_doe = 0;
      else if (p_rd) begin e_doe = 1; e_dout = mm[p_ra]; end
      if (p_wr) mm[p_wa] = p_wd;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    logic raw_rd, x_doe;
    raw_rd = !hb_cs_n && !hb_stb_a_n && (hb_mode == 1'b0 || hb_stb_b_n);
    if (!rst_n) begin
      chk(!reg_rd && !reg_wr && !hb_doe, "R5 reset quiet",
          {reg_rd, reg_wr, hb_doe}, 0);
    end else begin
      x_doe = e_doe && raw_rd;
      chk(reg_rd == e_rd, "R1/R7/R9 reg_rd", reg_rd, e_rd);
      chk(reg_wr == e_wr, "R2/R3/R9 reg_wr", reg_wr, e_wr);
      if (reg_rd && e_rd) chk(reg_addr == e_rd_addr, "R6 read address", reg_addr, e_rd_addr);
      if (reg_wr && e_wr) begin
        chk(reg_addr == e_wr_addr, "R6 write address", reg_addr, e_wr_addr);
        chk(reg_wdata == e_wdata, "R2 write data", reg_wdata, e_wdata);
      end
      chk(hb_doe == x_doe, "R4/R8 hb_doe", hb_doe, x_doe);
      if (hb_doe && x_doe) chk(hb_dout == e_dout, "R10 hb_dout", hb_dout, e_dout);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic delta(input int rd0, input int wr0, input int drd, input int dwr,
                       input string req);
    chk(cnt_rd - rd0 == drd, {req, " read count"}, cnt_rd - rd0, drd);
    chk(cnt_wr - wr0 == dwr, {req, " write count"}, cnt_wr - wr0, dwr);
  endtask

  // read with either style; checks the byte on the bus near the end
  task automatic host_read(input bit mode, input logic [10:0] a, input int hold,
                           input logic [7:0] exp, input string req);
    hb_mode = mode; hb_ale = 1'b1; hb_addr = a;
    hb_stb_b_n = 1'b1; hb_cs_n = 1'b0; hb_stb_a_n = 1'b0;
    step(hold);
    @(negedge clk);
    chk(hb_doe == 1'b1, {req, " bus driven"}, hb_doe, 1);
    chk(hb_dout == exp, {req, " bus data"}, hb_dout, exp);
    step(1);
    hb_stb_a_n = 1'b1; hb_cs_n = 1'b1;
    step(5);
  endtask

  task automatic host_write(input bit mode, input logic [10:0] a, input logic [7:0] d);
    hb_mode = mode; hb_ale = 1'b1; hb_addr = a; hb_din = ~d;
    hb_cs_n = 1'b0;
    if (mode) begin hb_stb_b_n = 1'b0; hb_stb_a_n = 1'b0; end
    else      hb_stb_b_n = 1'b0;
    step(3);
    hb_din = d;
    step(2);
    hb_stb_a_n = 1'b1; hb_stb_b_n = 1'b1; hb_cs_n = 1'b1; hb_din = 8'h5A;
    step(5);
  endtask

  initial begin
    int r0, w0;
    step(4);
    chk(!hb_doe && !reg_rd && !reg_wr, "R5 idle in reset", hb_doe, 0);
    rst_n = 1'b1;
    step(4);

    // R1, R7: split-strobe read
    r0 = cnt_rd; w0 = cnt_wr;
    host_read(1'b0, 11'h123, 6, 8'(11'h123 * 7 + 3), "R1");
    delta(r0, w0, 1, 0, "R1");

    // R2: data changes inside the strobe; value at release is kept
    r0 = cnt_rd; w0 = cnt_wr;
    host_write(1'b0, 11'h123, 8'hA5);
    delta(r0, w0, 0, 1, "R2");
    host_read(1'b0, 11'h123, 5, 8'hA5, "R2 readback");

    // R3: data-strobe style, both directions and address extremes
    r0 = cnt_rd; w0 = cnt_wr;
    host_write(1'b1, 11'h7FF, 8'h3C);
    host_write(1'b1, 11'h000, 8'hC3);
    host_read(1'b1, 11'h7FF, 5, 8'h3C, "R3");
    host_read(1'b1, 11'h000, 7, 8'hC3, "R3");
    delta(r0, w0, 2, 2, "R3");

    // R4: strobes toggle with chip select high
    r0 = cnt_rd; w0 = cnt_wr;
    hb_mode = 1'b0; hb_cs_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      hb_stb_a_n = 1'b0; step(4); hb_stb_a_n = 1'b1;
      hb_stb_b_n = 1'b0; step(4); hb_stb_b_n = 1'b1; step(2);
    end
    step(4);
    delta(r0, w0, 0, 0, "R4");
    chk(mem[11'h123] == 8'hA5, "R4 register untouched", mem[11'h123], 8'hA5);

    // R6: multiplexed address phase, junk on address during strobe
    r0 = cnt_rd; w0 = cnt_wr;
    hb_mode = 1'b0; hb_ale = 1'b1; hb_addr = 11'h2F0; step(2);
    hb_ale = 1'b0; step(1);
    hb_addr = 11'h7AA; hb_din = 8'h11; hb_cs_n = 1'b0; hb_stb_b_n = 1'b0;
    step(4);
    hb_din = 8'h96; step(1);
    hb_stb_b_n = 1'b1; hb_cs_n = 1'b1; step(5);
    hb_ale = 1'b1; step(2);
    delta(r0, w0, 0, 1, "R6");
    chk(mem[11'h2F0] == 8'h96, "R6 latched address written", mem[11'h2F0], 8'h96);
    chk(mem[11'h7AA] == 8'(11'h7AA * 7 + 3), "R6 live address untouched",
        mem[11'h7AA], 8'(11'h7AA * 7 + 3));

    // R7: very long read strobe
    r0 = cnt_rd; w0 = cnt_wr;
    host_read(1'b0, 11'h2F0, 25, 8'h96, "R7");
    delta(r0, w0, 1, 0, "R7");

    // R8: chip select withdrawn while the strobe stays low
    hb_mode = 1'b0; hb_addr = 11'h010; hb_cs_n = 1'b0; hb_stb_a_n = 1'b0;
    step(6);
    hb_cs_n = 1'b1;
    #1;
    chk(hb_doe == 1'b0, "R8 drop on chip select", hb_doe, 0);
    step(4);
    hb_stb_a_n = 1'b1; step(4);

    // R5: reset while driving read data
    hb_addr = 11'h020; hb_cs_n = 1'b0; hb_stb_a_n = 1'b0;
    step(6);
    chk(hb_doe == 1'b1, "R5 driving before reset", hb_doe, 1);
    rst_n = 1'b0;
    #1;
    chk(hb_doe == 1'b0, "R5 released in reset", hb_doe, 0);
    step(1);
    hb_cs_n = 1'b1; hb_stb_a_n = 1'b1;
    step(3);
    rst_n = 1'b1;
    step(6);

    // R9, R10 covered cycle by cycle; one more back-to-back pair
    host_write(1'b0, 11'h444, 8'h77);
    host_read(1'b1, 11'h444, 5, 8'h77, "R9/R10");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule